// File: doc/BRIEF.md
# Single-Descriptor DMA Fetch Engine

The engine moves one buffer between system memory and the byte-wide data path of a flash sequencer. It is driven by one descriptor held in memory. Software writes the descriptor's memory address into a base register and then pulses `start` with a direction and a flash byte count. The engine reads the descriptor and checks that software has handed it over and that it describes one complete buffer. It then streams the buffer in 8-byte memory beats, either out to the flash (transmit) or in from it (receive).

When the data has moved, the engine writes the descriptor's first word back with the ownership bit cleared. On the cycle after that write it raises a one-cycle completion pulse for the direction in use. If the descriptor is not usable, the engine raises a descriptor-unavailable pulse instead and touches no data. Memory is reached through a request/acknowledge port that carries one 64-bit beat per request.

Top module: `sdma_engine`

## Requirements
- R1: A write with `reg_addr` equal to 0x18 loads the descriptor base address with bits 2:0 forced to zero. Writes to any other offset have no effect. The base in use is captured at `start`, so a later write does not alter a transfer in flight.
- R2: The descriptor is fetched with two reads, at base and base+8. Word 0 (status) is bits 31:0 and word 1 (sizes) is bits 63:32 of the first beat. The buffer address is bits 31:0 of the second beat. Bits 63:32 of the second beat are ignored.
- R3: The descriptor is usable only if status bit 31 (ownership), bit 3 (first) and bit 2 (last) are all set. Otherwise `evt_no_desc` pulses for one cycle, no further memory access is made, no byte is streamed and the descriptor is left unchanged.
- R4: Sizes bits 11:0 give the buffer size in bytes. The engine moves ceil(size/8) beats at buffer+0, +8, +16 and so on, in ascending order. A size of zero moves no beats.
- R5: In transmit (`dir`=0), exactly `xfer_len` bytes leave on `tx_data`, lowest byte of each beat first, one per cycle with `tx_valid` and `tx_ready` both high. While stalled, `tx_data` holds.
- R6: In receive (`dir`=1), `xfer_len` bytes taken on `rx_valid`/`rx_ready` are packed little-endian into the beats. Every byte position at or past `xfer_len` in the written beats is zero.
- R7: After the data, the engine writes one beat at the base address. That beat holds the sizes word in bits 63:32 and the status word with bit 31 cleared, other bits unchanged, in bits 31:0.
- R8: The cycle after the write-back is acknowledged, `evt_tx_done` (transmit) or `evt_rx_done` (receive) is high for exactly one cycle. No two event outputs are ever high together.
- R9: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until the cycle in which `mem_ack` is high. Read data is taken in that cycle.
- R10: `busy` is high from the cycle after an accepted `start` until the event pulse. A `start` while busy is ignored. While idle there is no memory request, no `tx_valid` and no `rx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| start | input | 1 | Begin a transfer (one cycle) |
| dir | input | 1 | 0 = memory to flash, 1 = flash to memory |
| xfer_len | input | 12 | Flash byte count of the transfer |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, 8-byte aligned |
| mem_wdata | output | 64 | Write beat |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 64 | Read beat |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Sequencer takes the outgoing byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Engine takes the incoming byte |
| evt_tx_done | output | 1 | Transmit complete pulse |
| evt_rx_done | output | 1 | Receive complete pulse |
| evt_no_desc | output | 1 | Descriptor unavailable pulse |

## Verification
The assertions assume that the memory side obeys the request protocol. Acknowledge comes only while a request is pending, and read data is valid in the acknowledge cycle. They also assume that `xfer_len` never exceeds the descriptor size, so every byte counted has a beat to travel in. The bench memory model acknowledges each request exactly one cycle after it appears. The byte source and sink only offer or take bytes through the valid/ready pair. Every scenario keeps `xfer_len` at or below the programmed size, including the rounded-up and zero-size cases.

// File: rtl/sdma_pkg.sv
// Package: shared constants and the controller state type of the
// single-descriptor DMA engine. Assumes 32-bit descriptor words.
package sdma_pkg;
    localparam int DES_OWN_BIT   = 31;
    localparam int DES_FIRST_BIT = 3;
    localparam int DES_LAST_BIT  = 2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DESC0,
        S_DESC1,
        S_CHECK,
        S_TX_RD,
        S_TX_OUT,
        S_RX_IN,
        S_RX_WR,
        S_WBACK
    } sdma_state_e;
endpackage

// File: rtl/sdma_unpack.sv
// Beat-to-byte serializer: loads one memory beat and a byte count, then
// emits that many bytes, lowest first, on a valid/ready stream.
// Assumes load only arrives while the previous beat has fully drained.
module sdma_unpack #(
    parameter  int BEAT_BYTES = 8,
    localparam int DATA_W     = 8 * BEAT_BYTES,
    localparam int CHUNK_W    = $clog2(BEAT_BYTES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DATA_W-1:0]  beat,
    input  logic [CHUNK_W-1:0] nbytes,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    input  logic               tx_ready,
    output logic               busy
);
    logic [DATA_W-1:0]  beat_q;
    logic [CHUNK_W-1:0] left_q;

    // Hold the beat and shift one byte out per accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
            left_q <= '0;
        end else if (load) begin
            beat_q <= beat;
            left_q <= nbytes;
        end else if (tx_valid && tx_ready) begin
            beat_q <= beat_q >> 8;
            left_q <= left_q - CHUNK_W'(1);
        end
    end

    assign tx_valid = (left_q != '0);
    assign tx_data  = beat_q[7:0];
    assign busy     = tx_valid;
endmodule

// File: rtl/sdma_pack.sv
// Byte-to-beat packer: after start, collects nbytes bytes little-endian
// into one beat; untouched lanes stay zero. done holds until next start.
module sdma_pack #(
    parameter  int BEAT_BYTES = 8,
    localparam int DATA_W     = 8 * BEAT_BYTES,
    localparam int CHUNK_W    = $clog2(BEAT_BYTES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CHUNK_W-1:0] nbytes,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    output logic               rx_ready,
    output logic               done,
    output logic [DATA_W-1:0]  beat
);
    logic [CHUNK_W-1:0] cnt_q;
    logic [CHUNK_W-1:0] need_q;
    logic               done_q;
    logic               take;

    assign take     = rx_valid && rx_ready;
    assign rx_ready = !done_q;
    assign done     = done_q;

    // Track how many bytes of the current beat have arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            need_q <= '0;
            done_q <= 1'b1;
        end else if (start) begin
            cnt_q  <= '0;
            need_q <= nbytes;
            done_q <= (nbytes == '0);
        end else if (take) begin
            cnt_q <= cnt_q + CHUNK_W'(1);
            if (cnt_q + CHUNK_W'(1) == need_q) done_q <= 1'b1;
        end
    end

    for (genvar b = 0; b < BEAT_BYTES; b++) begin : g_lane
        logic [7:0] lane_q;
        // Capture the byte for this lane, clear the lane on a new beat.
        always_ff @(posedge clk) begin
            if (!rst_n || start) lane_q <= '0;
            else if (take && cnt_q == CHUNK_W'(b)) lane_q <= rx_data;
        end
        assign beat[8*b +: 8] = lane_q;
    end
endmodule

// File: rtl/sdma_ctrl.sv
// Transfer sequencer: fetches the two-beat descriptor, checks ownership and
// first/last marks, walks the buffer beat by beat, writes the status word
// back with ownership cleared and pulses the matching event.
// Assumes an 8-byte beat and a memory that acks each held request once.
module sdma_ctrl
    import sdma_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int BEAT_BYTES = 8,
    parameter  int SIZE_W     = 12,
    localparam int DATA_W     = 8 * BEAT_BYTES,
    localparam int CHUNK_W    = $clog2(BEAT_BYTES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic               start,
    input  logic               dir,
    input  logic [SIZE_W-1:0]  xfer_len,
    output logic               busy,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               unpack_load,
    output logic [CHUNK_W-1:0] chunk,
    input  logic               unpack_busy,
    output logic               pack_start,
    input  logic               pack_done,
    input  logic [DATA_W-1:0]  pack_beat,
    output logic               evt_tx_done,
    output logic               evt_rx_done,
    output logic               evt_no_desc
);
    localparam int BEAT_SH = $clog2(BEAT_BYTES);
    localparam int NBEAT_W = SIZE_W + 1 - BEAT_SH;

    sdma_state_e        state_q;
    logic               dir_q;
    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  buf_q;
    logic [31:0]        des0_q;
    logic [31:0]        des1_q;
    logic [SIZE_W-1:0]  left_q;
    logic [NBEAT_W-1:0] idx_q;
    logic [NBEAT_W-1:0] total_q;

    logic               desc_ok;
    logic [NBEAT_W-1:0] nbeats_c;
    logic [ADDR_W-1:0]  beat_addr;
    logic               last_beat;
    logic [31:0]        des0_wb;

    assign desc_ok   = des0_q[DES_OWN_BIT] && des0_q[DES_FIRST_BIT] && des0_q[DES_LAST_BIT];
    assign nbeats_c  = NBEAT_W'(({1'b0, des1_q[SIZE_W-1:0]} + (SIZE_W+1)'(BEAT_BYTES - 1)) >> BEAT_SH);
    assign beat_addr = buf_q + (ADDR_W'(idx_q) << BEAT_SH);
    assign last_beat = (idx_q + NBEAT_W'(1)) == total_q;
    assign chunk     = (left_q >= SIZE_W'(BEAT_BYTES)) ? CHUNK_W'(BEAT_BYTES) : CHUNK_W'(left_q);
    assign des0_wb   = des0_q & ~(32'h1 << DES_OWN_BIT);
    assign busy      = (state_q != S_IDLE);

    // Drive the memory request and the serializer/packer strobes per state.
    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        unpack_load = 1'b0;
        pack_start  = 1'b0;
        case (state_q)
            S_DESC0: begin
                mem_req  = 1'b1;
                mem_addr = base_q;
            end
            S_DESC1: begin
                mem_req  = 1'b1;
                mem_addr = base_q + ADDR_W'(BEAT_BYTES);
            end
            S_CHECK: pack_start = desc_ok && dir_q && (nbeats_c != '0);
            S_TX_RD: begin
                mem_req     = 1'b1;
                mem_addr    = beat_addr;
                unpack_load = mem_ack;
            end
            S_RX_WR: begin
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                mem_addr   = beat_addr;
                mem_wdata  = pack_beat;
                pack_start = mem_ack && !last_beat;
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base_q;
                mem_wdata = DATA_W'({des1_q, des0_wb});
            end
            default: ;
        endcase
    end

    // Advance the transfer sequence and register the event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            dir_q       <= 1'b0;
            base_q      <= '0;
            buf_q       <= '0;
            des0_q      <= '0;
            des1_q      <= '0;
            left_q      <= '0;
            idx_q       <= '0;
            total_q     <= '0;
            evt_tx_done <= 1'b0;
            evt_rx_done <= 1'b0;
            evt_no_desc <= 1'b0;
        end else begin
            evt_tx_done <= 1'b0;
            evt_rx_done <= 1'b0;
            evt_no_desc <= 1'b0;
            if (unpack_load || pack_start) left_q <= left_q - SIZE_W'(chunk);
            case (state_q)
                S_IDLE: if (start) begin
                    dir_q   <= dir;
                    base_q  <= base_addr;
                    left_q  <= xfer_len;
                    state_q <= S_DESC0;
                end
                S_DESC0: if (mem_ack) begin
                    des0_q  <= mem_rdata[31:0];
                    des1_q  <= mem_rdata[32 +: 32];
                    state_q <= S_DESC1;
                end
                S_DESC1: if (mem_ack) begin
                    buf_q   <= mem_rdata[ADDR_W-1:0];
                    state_q <= S_CHECK;
                end
                S_CHECK: begin
                    if (!desc_ok) begin
                        evt_no_desc <= 1'b1;
                        state_q     <= S_IDLE;
                    end else begin
                        total_q <= nbeats_c;
                        idx_q   <= '0;
                        if (nbeats_c == '0) state_q <= S_WBACK;
                        else if (dir_q)     state_q <= S_RX_IN;
                        else                state_q <= S_TX_RD;
                    end
                end
                S_TX_RD: if (mem_ack) state_q <= S_TX_OUT;
                S_TX_OUT: if (!unpack_busy) begin
                    idx_q   <= idx_q + NBEAT_W'(1);
                    state_q <= last_beat ? S_WBACK : S_TX_RD;
                end
                S_RX_IN: if (pack_done) state_q <= S_RX_WR;
                S_RX_WR: if (mem_ack) begin
                    idx_q   <= idx_q + NBEAT_W'(1);
                    state_q <= last_beat ? S_WBACK : S_RX_IN;
                end
                S_WBACK: if (mem_ack) begin
                    evt_tx_done <= !dir_q;
                    evt_rx_done <= dir_q;
                    state_q     <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdma_engine.sv
// Top of the single-descriptor DMA engine: holds the descriptor base
// register and joins the sequencer, the transmit serializer and the
// receive packer. Assumes beat-aligned descriptors and buffers.
module sdma_engine #(
    parameter int          ADDR_W     = 32,
    parameter int          BEAT_BYTES = 8,
    parameter int          SIZE_W     = 12,
    parameter int          REG_AW     = 8,
    parameter logic [7:0]  BASE_OFS   = 8'h18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [REG_AW-1:0]         reg_addr,
    input  logic [ADDR_W-1:0]         reg_wdata,
    input  logic                      start,
    input  logic                      dir,
    input  logic [SIZE_W-1:0]         xfer_len,
    output logic                      busy,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [8*BEAT_BYTES-1:0]   mem_wdata,
    input  logic                      mem_ack,
    input  logic [8*BEAT_BYTES-1:0]   mem_rdata,
    output logic                      tx_valid,
    output logic [7:0]                tx_data,
    input  logic                      tx_ready,
    input  logic                      rx_valid,
    input  logic [7:0]                rx_data,
    output logic                      rx_ready,
    output logic                      evt_tx_done,
    output logic                      evt_rx_done,
    output logic                      evt_no_desc
);
    localparam int DATA_W  = 8 * BEAT_BYTES;
    localparam int BEAT_SH = $clog2(BEAT_BYTES);
    localparam int CHUNK_W = BEAT_SH + 1;

    logic [ADDR_W-1:0]  base_q;
    logic               unpack_load;
    logic               unpack_busy;
    logic [CHUNK_W-1:0] chunk;
    logic               pack_start;
    logic               pack_done;
    logic [DATA_W-1:0]  pack_beat;
    logic               unused_low;

    assign unused_low = ^reg_wdata[BEAT_SH-1:0];

    // Load the descriptor base on a write to its offset, beat aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else if (reg_wr && reg_addr == REG_AW'(BASE_OFS))
            base_q <= {reg_wdata[ADDR_W-1:BEAT_SH], {BEAT_SH{1'b0}}};
    end

    sdma_ctrl #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES), .SIZE_W(SIZE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .base_addr(base_q), .start(start), .dir(dir),
        .xfer_len(xfer_len), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .unpack_load(unpack_load), .chunk(chunk),
        .unpack_busy(unpack_busy), .pack_start(pack_start), .pack_done(pack_done),
        .pack_beat(pack_beat), .evt_tx_done(evt_tx_done),
        .evt_rx_done(evt_rx_done), .evt_no_desc(evt_no_desc)
    );

    sdma_unpack #(.BEAT_BYTES(BEAT_BYTES)) u_unpack (
        .clk(clk), .rst_n(rst_n), .load(unpack_load), .beat(mem_rdata),
        .nbytes(chunk), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .busy(unpack_busy)
    );

    sdma_pack #(.BEAT_BYTES(BEAT_BYTES)) u_pack (
        .clk(clk), .rst_n(rst_n), .start(pack_start), .nbytes(chunk),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .done(pack_done), .beat(pack_beat)
    );
endmodule

// File: rtl/sdma_checks.sv
// Protocol checker for sdma_engine, attached by bind. Assumes the memory
// acknowledges only pending requests.
module sdma_checks #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_ready,
    input logic              rx_ready,
    input logic              evt_tx_done,
    input logic              evt_rx_done,
    input logic              evt_no_desc
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R5
    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_tx_done, evt_rx_done, evt_no_desc})); // R8
    AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_done |=> !evt_tx_done); // R8
    AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_done |=> !evt_rx_done); // R8
    AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_tx_done || evt_rx_done) |-> $past(mem_req && mem_ack && mem_we && !mem_wdata[31])); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !tx_valid && !rx_ready); // R10
endmodule

bind sdma_engine sdma_checks #(.ADDR_W(ADDR_W), .DATA_W(8 * BEAT_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_ready(rx_ready), .evt_tx_done(evt_tx_done), .evt_rx_done(evt_rx_done),
    .evt_no_desc(evt_no_desc)
);

// File: tb/sim_sdma_engine.sv
module sim_sdma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        start = 1'b0;
    logic        dir = 1'b0;
    logic [11:0] xfer_len = '0;
    logic        busy, mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        tx_valid, tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0, rx_ready;
    logic [7:0]  rx_data = '0;
    logic        evt_tx_done, evt_rx_done, evt_no_desc;

    always #4 clk = ~clk;   // 125 MHz

    sdma_engine u0 (.*);

    logic [63:0] mem [0:63];
    logic [7:0]  tx_got [0:255];
    logic [7:0]  rx_src [0:255];
    int          tx_cnt, rx_idx, rx_total, rd_cnt, wr_cnt;
    int          ev_tx, ev_rx, ev_nd;
    logic [31:0] rd_first, wr_last;
    logic        own_seen, stall;
    int          checks = 0, errors = 0;

    // Memory model, byte sink and event recorder.
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) mem_rdata <= mem[mem_addr[8:3]];
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    mem[mem_addr[8:3]] <= mem_wdata;
                    wr_cnt  <= wr_cnt + 1;
                    wr_last <= mem_addr;
                end else begin
                    if (rd_cnt == 0) rd_first <= mem_addr;
                    rd_cnt <= rd_cnt + 1;
                end
            end
            if (tx_valid && tx_ready) begin
                tx_got[tx_cnt] <= tx_data;
                tx_cnt <= tx_cnt + 1;
            end
            if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
            if (evt_tx_done) ev_tx <= ev_tx + 1;
            if (evt_rx_done) ev_rx <= ev_rx + 1;
            if (evt_no_desc) ev_nd <= ev_nd + 1;
            if (evt_tx_done || evt_rx_done) own_seen <= mem[32][31];
        end
    end

    // Byte source and sink flow control, driven away from the active edge.
    always @(negedge clk) begin
        tx_ready <= stall ? ~tx_ready : 1'b1;
        rx_valid <= (rx_idx < rx_total);
        rx_data  <= rx_src[rx_idx];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_desc(input logic [31:0] des0, input logic [31:0] size);
        mem[32] = {size, des0};
        mem[33] = {32'hDEAD_BEEF, 32'h0000_0040};
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run(input logic d, input logic [11:0] len, input bit poke);
        @(negedge clk);
        tx_cnt = 0; rd_cnt = 0; wr_cnt = 0; ev_tx = 0; ev_rx = 0; ev_nd = 0;
        rx_idx = 0; own_seen = 1'b1;
        start = 1'b1; dir = d; xfer_len = len;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (6) @(negedge clk);
            start = 1'b1; dir = ~d; reg_wr = 1'b1; reg_addr = 8'h18; reg_wdata = 32'h0;
            @(negedge clk);
            start = 1'b0; reg_wr = 1'b0;
        end
        for (int i = 0; i < 3000; i++) begin
            if ((ev_tx + ev_rx + ev_nd) > 0 && !busy) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [7:0] bufbyte(input int j);
        return mem[8 + j / 8][8 * (j % 8) +: 8];
    endfunction

    task automatic t_reset;
        chk(!busy && !mem_req && !tx_valid && !rx_ready, "R10", "idle after reset",
            {busy, mem_req, tx_valid, rx_ready}, 0);
        chk(!evt_tx_done && !evt_rx_done && !evt_no_desc, "R8", "no event after reset",
            {evt_tx_done, evt_rx_done, evt_no_desc}, 0);
    endtask

    task automatic t_tx(input int size, input int len, input bit stl);
        int bad = 0;
        int beats = (size + 7) / 8;
        set_desc(32'h8000_104C, size);
        for (int j = 0; j < 32; j++) mem[8 + j / 8][8 * (j % 8) +: 8] = 8'h10 + 8'(j);
        stall = stl;
        run(1'b0, 12'(len), 1'b0);
        stall = 1'b0;
        chk(rd_first == 32'h100, "R1", "descriptor read at base", rd_first, 32'h100);
        chk(rd_cnt == 2 + beats, "R4", "reads = 2 + beats", rd_cnt, 2 + beats);
        chk(tx_cnt == len, "R5", "bytes streamed", tx_cnt, len);
        for (int j = 0; j < len; j++) if (tx_got[j] != 8'h10 + 8'(j)) bad++;
        chk(bad == 0, "R5", "byte order", bad, 0);
        chk(mem[32] == {32'(size), 32'h0000_104C}, "R7", "status written back", mem[32],
            {32'(size), 32'h0000_104C});
        chk(ev_tx == 1 && ev_rx == 0, "R8", "tx completion pulse", ev_tx * 16 + ev_rx, 16);
        chk(own_seen == 1'b0, "R7", "ownership cleared before flag", own_seen, 0);
        chk(mem[33] == {32'hDEAD_BEEF, 32'h40}, "R2", "second word untouched", mem[33],
            {32'hDEAD_BEEF, 32'h40});
    endtask

    task automatic t_rx;
        mem[8] = '1; mem[9] = '1;
        set_desc(32'h8000_000C, 16);
        for (int j = 0; j < 11; j++) rx_src[j] = 8'hA0 + 8'(j);
        rx_total = 11;
        run(1'b1, 12'd11, 1'b0);
        rx_total = 0;
        chk(mem[8] == 64'hA7A6_A5A4_A3A2_A1A0, "R6", "first beat packed", mem[8],
            64'hA7A6_A5A4_A3A2_A1A0);
        chk(mem[9] == 64'h0000_0000_00AA_A9A8, "R6", "tail zero padded", mem[9],
            64'h0000_0000_00AA_A9A8);
        chk(wr_cnt == 3 && wr_last == 32'h100, "R7", "writes then write-back", wr_cnt, 3);
        chk(ev_rx == 1 && ev_tx == 0, "R8", "rx completion pulse", ev_rx * 16 + ev_tx, 16);
        chk(mem[32][31] == 1'b0, "R7", "ownership cleared", mem[32][31], 0);
    endtask

    task automatic t_nodesc(input logic [31:0] des0);
        set_desc(des0, 16);
        run(1'b0, 12'd16, 1'b0);
        chk(ev_nd == 1 && ev_tx == 0, "R3", "unavailable pulse", ev_nd * 16 + ev_tx, 16);
        chk(rd_cnt == 2 && wr_cnt == 0 && tx_cnt == 0, "R3", "no data movement",
            rd_cnt * 256 + wr_cnt * 16 + tx_cnt, 512);
        chk(mem[32] == {32'd16, des0}, "R3", "descriptor unchanged", mem[32], {32'd16, des0});
    endtask

    task automatic t_zero;
        set_desc(32'h8000_000C, 0);
        run(1'b0, 12'd0, 1'b0);
        chk(rd_cnt == 2 && tx_cnt == 0 && wr_cnt == 1, "R4", "zero size moves no beat",
            rd_cnt * 256 + tx_cnt * 16 + wr_cnt, 513);
        chk(ev_tx == 1, "R8", "zero size still completes", ev_tx, 1);
    endtask

    task automatic t_busy;
        int bad = 0;
        set_desc(32'h8000_000C, 24);
        stall = 1'b1;
        run(1'b0, 12'd24, 1'b1);
        stall = 1'b0;
        for (int j = 0; j < 24; j++) if (tx_got[j] != bufbyte(j)) bad++;
        chk(tx_cnt == 24 && bad == 0, "R10", "second start ignored", tx_cnt * 256 + bad, 24 * 256);
        chk(ev_tx == 1 && ev_rx == 0, "R10", "one completion only", ev_tx * 16 + ev_rx, 16);
        chk(wr_last == 32'h100, "R1", "base latched at start", wr_last, 32'h100);
        reg_write(8'h18, 32'h0000_0100);
    endtask

    initial begin
        stall = 1'b0; rx_total = 0; rx_idx = 0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        reg_write(8'h18, 32'h0000_0107);   // low bits dropped (R1)
        reg_write(8'h1C, 32'h0000_0000);   // other offset ignored (R1)
        t_tx(16, 16, 1'b1);                // R9: held requests, stalled sink
        t_tx(13, 13, 1'b0);                // rounded up to two beats (R4)
        t_rx();
        t_nodesc(32'h0000_000C);           // ownership clear
        t_nodesc(32'h8000_0008);           // last mark clear
        t_zero();
        t_busy();
        t_tx(8, 5, 1'b0);                  // base restored, short length
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule